// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Model

This block is a synthesizable serial EEPROM target for a 1024-byte array. It sits on an SPI bus in mode 0: input bits are taken on the rising edge of the serial clock, and output bits change on the falling edge. The chip select, serial clock and serial data input are brought into the system clock domain through synchronizers. Edges are found there, and all serial state advances on the system clock.

Four commands are decoded: write-enable (0x06), write (0x02), read-status (0x05) and read (0x03). A write command carries a 16-bit address and is followed by data bytes, which go into a 32-byte page buffer. The write is committed only when chip select rises on a clean byte boundary. The block then runs a timed programming cycle of `PROG_CYCLES` system clocks. During that cycle the marked page-buffer entries are copied into the array, and only read-status is served. When the cycle ends, the write-enable latch clears.

The block-protection level is a two-bit input that the status register reflects. A write whose page lies in the protected range is refused.

Top module: `eep_spi_model`

## Requirements
- R1: A write command is accepted only while the write-enable latch is set. The write-enable command (0x06) sets the latch. A write (0x02) sent while the latch is clear leaves the array unchanged and starts no programming cycle.
- R2: A write frame carries the opcode, a 16-bit address and data bytes, all MSB first. A read frame (0x03 plus a 16-bit address) returns array bytes from that address onward on `miso`, MSB first, with the address incrementing across the array.
- R3: Only address bits 9..0 select a byte; bits 15..10 have no effect on writes or reads.
- R4: Within a write frame, only the low five address bits advance after each data byte. Bytes beyond 32 wrap inside the same page, and the last byte sent to a position wins.
- R5: A write is committed only if chip select rises while the serial clock is low, after a whole number of data bytes with at least one data byte. If chip select rises at any other point, the array is left unchanged, no cycle starts and the write-enable latch is kept.
- R6: A write is refused when its page is protected. Level 0 protects nothing, level 1 protects 0x300–0x3FF, level 2 protects 0x200–0x3FF and level 3 protects the whole array. A refused write leaves the array and the write-enable latch unchanged.
- R7: Status bit 0 is 1 from the commit until `PROG_CYCLES` clocks later. While it is 1, every command other than read-status is ignored.
- R8: The write-enable latch (status bit 1) clears when the programming cycle ends.
- R9: `miso_oe` is 0 whenever chip select has been high for at least four system clocks. The data output is then treated as high-impedance.
- R10: The read-status byte is {4'b0000, protection level (bits 3:2), write-enable latch (bit 1), busy (bit 0)}, and reads 0x00 after reset with level 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock, idle low |
| mosi | input | 1 | SPI serial data into the block |
| prot_lvl | input | 2 | Block-protection level shown in status bits 3:2 |
| miso | output | 1 | SPI serial data out of the block |
| miso_oe | output | 1 | Drive enable for `miso`; low means high-impedance |

## Verification
The assertions assume that each serial-clock half period and each chip-select level lasts longer than the synchronizer delay, so every edge is seen exactly once in the system clock domain. They also assume that `PROG_CYCLES` is larger than the 32-entry page. The stimulus holds every SCK phase for eight system clocks and keeps chip select high for sixteen between frames. It changes `prot_lvl` only between frames, and it instantiates the block with a programming cycle far longer than the page.

// File: rtl/eep_pkg.sv
package eep_pkg;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_READ  = 8'h03;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT,
    ST_STAT,
    ST_SKIP
  } eep_state_e;

  // Advance only the in-page offset, keeping the page number.
  function automatic logic [4:0] page_offset_next(logic [4:0] off);
    return off + 5'd1;
  endfunction

  // top2 holds the two most significant array address bits.
  function automatic logic in_protected(logic [1:0] top2, logic [1:0] lvl);
    case (lvl)
      2'b00:   return 1'b0;
      2'b01:   return top2 == 2'b11;
      2'b10:   return top2[1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] status_byte(logic [1:0] lvl, logic wel, logic busy);
    return {4'b0000, lvl, wel, busy};
  endfunction

endpackage

// File: rtl/eep_spi_front.sv
module eep_spi_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       mosi,
  input  logic [7:0] tx_byte,
  output logic       sel,
  output logic       frame_end,
  output logic       frame_clean,
  output logic       byte_vld,
  output logic [7:0] byte_data,
  output logic       miso,
  output logic       miso_oe
);

  logic [SYNC_STAGES-1:0] cs_sr, sck_sr, mosi_sr;
  logic cs_s, sck_s, mosi_s;
  logic cs_d, sck_d;
  logic sck_rise, sck_fall;
  logic [2:0] bit_cnt;
  logic [6:0] shreg;
  logic [7:0] tx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sr   <= '1;
      sck_sr  <= '0;
      mosi_sr <= '0;
      cs_d    <= 1'b1;
      sck_d   <= 1'b0;
    end else begin
      cs_sr   <= {cs_sr[SYNC_STAGES-2:0], cs_n};
      sck_sr  <= {sck_sr[SYNC_STAGES-2:0], sck};
      mosi_sr <= {mosi_sr[SYNC_STAGES-2:0], mosi};
      cs_d    <= cs_s;
      sck_d   <= sck_s;
    end
  end

  assign cs_s   = cs_sr[SYNC_STAGES-1];
  assign sck_s  = sck_sr[SYNC_STAGES-1];
  assign mosi_s = mosi_sr[SYNC_STAGES-1];

  assign sck_rise    = sck_s & ~sck_d;
  assign sck_fall    = ~sck_s & sck_d;
  assign sel         = ~cs_s;
  assign frame_end   = cs_s & ~cs_d;
  assign frame_clean = frame_end & (bit_cnt == 3'd0) & ~sck_s;
  assign byte_vld    = sel & sck_rise & (bit_cnt == 3'd7);
  assign byte_data   = {shreg, mosi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (cs_s) begin
      bit_cnt <= '0;
    end else if (sck_rise) begin
      bit_cnt <= bit_cnt + 3'd1;
      shreg   <= {shreg[5:0], mosi_s};
    end
  end

  // Output shifter: reload on the falling edge that follows a byte boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
    end else if (cs_s) begin
      tx_sh <= '0;
    end else if (sck_fall) begin
      tx_sh <= (bit_cnt == 3'd0) ? tx_byte : {tx_sh[6:0], 1'b0};
    end
  end

  assign miso    = tx_sh[7];
  assign miso_oe = sel;

  // R9
  tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (tx_sh == 8'h00));

endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int PAGE_W      = 5,
  parameter int PROG_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              frame_end,
  input  logic              frame_clean,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  input  logic [1:0]        prot_lvl,
  input  logic [7:0]        arr_rdata,
  output logic [7:0]        tx_byte,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_waddr,
  output logic [7:0]        arr_wdata,
  output logic [ADDR_W-1:0] arr_raddr,
  output logic              busy,
  output logic              wel
);

  localparam int PAGE  = 1 << PAGE_W;
  localparam int HI_W  = ADDR_W - 8;
  localparam int PG_W  = ADDR_W - PAGE_W;
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST     = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] PAGE_LIM = CNT_W'(PAGE);

  eep_state_e        state;
  logic              is_read;
  logic [HI_W-1:0]   addr_hi;
  logic [ADDR_W-1:0] addr;
  logic [ADDR_W-1:0] full_addr;
  logic [7:0]        pbuf [PAGE];
  logic [PAGE-1:0]   mask;
  logic              have_data;
  logic [CNT_W-1:0]  busy_cnt;
  logic [PG_W-1:0]   page_base;
  logic [PAGE_W-1:0] copy_slot;
  logic              prog_done;
  logic              prot_hit;
  logic              commit;

  assign full_addr = {addr_hi, byte_data};
  assign arr_raddr = (state == ST_ALO) ? full_addr : addr;
  assign prot_hit  = in_protected(addr[ADDR_W-1 -: 2], prot_lvl);
  assign commit    = frame_end & frame_clean & (state == ST_WDAT) & have_data
                   & wel & ~busy & ~prot_hit;
  assign prog_done = busy & (busy_cnt == LAST);
  assign copy_slot = busy_cnt[PAGE_W-1:0];
  assign arr_we    = busy & (busy_cnt < PAGE_LIM) & mask[copy_slot];
  assign arr_waddr = {page_base, copy_slot};
  assign arr_wdata = pbuf[copy_slot];

  // Command, address and page-buffer path.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_CMD;
      is_read   <= 1'b0;
      addr_hi   <= '0;
      addr      <= '0;
      mask      <= '0;
      have_data <= 1'b0;
      tx_byte   <= '0;
      for (int i = 0; i < PAGE; i++) pbuf[i] <= '0;
    end else if (!sel) begin
      state <= ST_CMD;
    end else if (byte_vld) begin
      unique case (state)
        ST_CMD: begin
          tx_byte <= 8'h00;
          if (byte_data == OP_RDSR) begin
            state   <= ST_STAT;
            tx_byte <= status_byte(prot_lvl, wel, busy);
          end else if (busy) begin
            state <= ST_SKIP;
          end else if (byte_data == OP_WRITE && wel) begin
            state   <= ST_AHI;
            is_read <= 1'b0;
          end else if (byte_data == OP_READ) begin
            state   <= ST_AHI;
            is_read <= 1'b1;
          end else begin
            state <= ST_SKIP;
          end
        end
        ST_AHI: begin
          addr_hi <= byte_data[HI_W-1:0];
          state   <= ST_ALO;
        end
        ST_ALO: begin
          if (is_read) begin
            tx_byte <= arr_rdata;
            addr    <= full_addr + ADDR_W'(1);
            state   <= ST_RDAT;
          end else begin
            addr      <= full_addr;
            mask      <= '0;
            have_data <= 1'b0;
            state     <= ST_WDAT;
          end
        end
        ST_WDAT: begin
          pbuf[addr[PAGE_W-1:0]] <= byte_data;
          mask[addr[PAGE_W-1:0]] <= 1'b1;
          have_data              <= 1'b1;
          addr <= {addr[ADDR_W-1:PAGE_W], page_offset_next(addr[PAGE_W-1:0])};
        end
        ST_RDAT: begin
          tx_byte <= arr_rdata;
          addr    <= addr + ADDR_W'(1);
        end
        ST_STAT: tx_byte <= status_byte(prot_lvl, wel, busy);
        default: ;
      endcase
    end
  end

  // Programming timer and write-enable latch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      busy_cnt  <= '0;
      page_base <= '0;
      wel       <= 1'b0;
    end else begin
      if (commit) begin
        busy      <= 1'b1;
        busy_cnt  <= '0;
        page_base <= addr[ADDR_W-1:PAGE_W];
      end else if (prog_done) begin
        busy <= 1'b0;
      end else if (busy) begin
        busy_cnt <= busy_cnt + CNT_W'(1);
      end
      if (prog_done) begin
        wel <= 1'b0;
      end else if (sel && byte_vld && state == ST_CMD && !busy && byte_data == OP_WREN) begin
        wel <= 1'b1;
      end
    end
  end

  // R1
  wel_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wel);

  // R6
  prot_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(prot_hit));

  // R8
  wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);

  // R7
  no_write_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (state != ST_WDAT));

endmodule

// File: rtl/eep_spi_model.sv
module eep_spi_model #(
  parameter int PROG_CYCLES = 1000,
  parameter int ADDR_W      = 10,
  parameter int PAGE_W      = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       mosi,
  input  logic [1:0] prot_lvl,
  output logic       miso,
  output logic       miso_oe
);

  logic              sel, frame_end, frame_clean, byte_vld;
  logic [7:0]        byte_data, tx_byte, arr_rdata, arr_wdata;
  logic              arr_we, busy, wel;
  logic [ADDR_W-1:0] arr_waddr, arr_raddr;

  eep_spi_front #(.SYNC_STAGES(2)) u_front (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .tx_byte(tx_byte), .sel(sel), .frame_end(frame_end),
    .frame_clean(frame_clean), .byte_vld(byte_vld), .byte_data(byte_data),
    .miso(miso), .miso_oe(miso_oe)
  );

  eep_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PROG_CYCLES(PROG_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sel(sel), .frame_end(frame_end),
    .frame_clean(frame_clean), .byte_vld(byte_vld), .byte_data(byte_data),
    .prot_lvl(prot_lvl), .arr_rdata(arr_rdata), .tx_byte(tx_byte),
    .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata),
    .arr_raddr(arr_raddr), .busy(busy), .wel(wel)
  );

  eep_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
    .clk(clk), .rst_n(rst_n), .we(arr_we), .waddr(arr_waddr),
    .wdata(arr_wdata), .raddr(arr_raddr), .rdata(arr_rdata)
  );

  // R5
  clean_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(frame_clean));

endmodule

// File: tb/tb_eep_spi_model.sv
module tb_eep_spi_model;
  typedef logic [7:0] u8;

  localparam int H    = 8;
  localparam int PROG = 1500;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic [1:0] prot_lvl = 2'b00;
  logic miso, miso_oe;

  int checks = 0, fails = 0, cs_high = 0;
  u8  txq[$], rxq[$];
  u8  mem_m [1024];
  bit wel_m = 0;

  always #10 clk = ~clk;

  eep_spi_model #(.PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .prot_lvl(prot_lvl), .miso(miso), .miso_oe(miso_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-clock comparison of the output enable against the model (R9).
  always @(negedge clk) begin
    if (cs_n) cs_high++; else cs_high = 0;
    if (rst_n && cs_high >= 4) chk("R9 miso_oe idle", int'(miso_oe), 0);
  end

  task automatic run_frame(input int trail);
    u8 r;
    rxq.delete();
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    foreach (txq[k]) begin
      for (int i = 7; i >= 0; i--) begin
        mosi = txq[k][i];
        repeat (H) @(negedge clk);
        r[i] = miso;
        sck = 1'b1;
        repeat (H) @(negedge clk);
        sck = 1'b0;
      end
      rxq.push_back(r);
    end
    for (int i = 0; i < trail; i++) begin
      mosi = 1'b1;
      repeat (H) @(negedge clk);
      sck = 1'b1;
      repeat (H) @(negedge clk);
      sck = 1'b0;
    end
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * H) @(negedge clk);
  endtask

  function automatic int exp_stat(input bit bsy);
    return (int'(prot_lvl) << 2) | (int'(wel_m) << 1) | int'(bsy);
  endfunction

  function automatic bit prot_m(input int a);
    case (prot_lvl)
      2'd0: return 0;
      2'd1: return a >= 768;
      2'd2: return a >= 512;
      default: return 1;
    endcase
  endfunction

  task automatic rdsr(output u8 s);
    txq = '{8'h05, 8'h00};
    run_frame(0);
    s = rxq[1];
  endtask

  task automatic wren();
    txq = '{8'h06};
    run_frame(0);
    wel_m = 1;
  endtask

  // Sends a write frame and updates the model when it commits; returns commit.
  task automatic do_write(input int a16, input u8 d[$], input int trail, output bit committed);
    int a;
    txq = '{8'h02, u8'(a16 >> 8), u8'(a16)};
    foreach (d[k]) txq.push_back(d[k]);
    run_frame(trail);
    a = a16 & 1023;
    committed = wel_m && !prot_m(a) && trail == 0 && d.size() > 0;
    if (committed)
      foreach (d[k]) mem_m[(a & ~31) | ((a + k) & 31)] = d[k];
  endtask

  task automatic wait_ready(input string req);
    u8 s;
    int polls = 0;
    do begin
      rdsr(s);
      polls++;
    end while (s[0] && polls < 30);
    chk(req, int'(s[0]), 0);
    wel_m = 0;
    chk("R8 latch cleared after cycle", int'(s), exp_stat(0));
  endtask

  task automatic verify(input string req, input int a16, input int n);
    txq = '{8'h03, u8'(a16 >> 8), u8'(a16)};
    for (int i = 0; i < n; i++) txq.push_back(8'h00);
    run_frame(0);
    for (int i = 0; i < n; i++)
      chk(req, int'(rxq[3 + i]), int'(mem_m[((a16 & 1023) + i) % 1024]));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    u8 s;
    u8 d[$];
    bit c;
    for (int i = 0; i < 1024; i++) mem_m[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10 reset status
    rdsr(s);
    chk("R10 reset status", int'(s), 0);

    // R1 write without enable is ignored
    d = '{8'h11, 8'h22};
    do_write(16'h0040, d, 0, c);
    rdsr(s);
    chk("R1 no busy without latch", int'(s), exp_stat(0));
    verify("R1 array untouched", 16'h0040, 2);

    // R1 / R10 enable latch visible in status
    wren();
    rdsr(s);
    chk("R1 R10 latch set", int'(s), 2);

    // R2 R3 R7 write with junk upper address bits
    d = '{8'hA5, 8'h3C, 8'h7E};
    do_write(16'hFC10, d, 0, c);
    rdsr(s);
    chk("R7 busy after commit", int'(s), exp_stat(1));
    // R7: write attempt during the cycle is ignored
    d = '{8'h77};
    txq = '{8'h02, 8'h01, 8'h00, 8'h77};
    run_frame(0);
    wait_ready("R7 busy ends");
    verify("R2 readback", 16'h0010, 3);
    verify("R3 upper bits ignored", 16'h0410, 3);
    verify("R7 busy write ignored", 16'h0100, 1);

    // R4 page wrap with 34 bytes starting at offset 30
    wren();
    d.delete();
    for (int i = 0; i < 34; i++) d.push_back(u8'(8'h40 + i));
    do_write(16'h005E, d, 0, c);
    wait_ready("R7 busy ends after page");
    verify("R4 page wrap", 16'h0040, 32);
    verify("R4 next page untouched", 16'h0060, 1);

    // R5 aborted mid-byte
    wren();
    d = '{8'h99};
    do_write(16'h0080, d, 3, c);
    rdsr(s);
    chk("R5 no busy on abort", int'(s), exp_stat(0));
    verify("R5 array unchanged", 16'h0080, 1);
    // R5 no data bytes at all
    d.delete();
    do_write(16'h0081, d, 0, c);
    rdsr(s);
    chk("R5 no busy without data", int'(s), exp_stat(0));

    // R6 protection level 2
    prot_lvl = 2'd2;
    repeat (4) @(negedge clk);
    d = '{8'hC3};
    do_write(16'h0300, d, 0, c);
    rdsr(s);
    chk("R6 R10 refused write status", int'(s), exp_stat(0));
    verify("R6 protected unchanged", 16'h0300, 1);
    d = '{8'h5A};
    do_write(16'h0100, d, 0, c);
    wait_ready("R7 busy ends unprotected");
    verify("R6 unprotected written", 16'h0100, 1);

    // R6 level 1 boundary and level 3
    prot_lvl = 2'd1;
    wren();
    d = '{8'h6B};
    do_write(16'h02E0, d, 0, c);
    wait_ready("R7 busy ends level1");
    verify("R6 below quarter written", 16'h02E0, 1);
    prot_lvl = 2'd3;
    wren();
    d = '{8'hEE};
    do_write(16'h0000, d, 0, c);
    rdsr(s);
    chk("R6 R10 full protect status", int'(s), exp_stat(0));
    verify("R6 full protect unchanged", 16'h0000, 1);

    finish_run();
  end
endmodule